// File: doc/BRIEF.md
# Serial Controller Interrupt Arbiter and Identifier

This block decides which interrupt a 16550-style serial controller raises and tells software which source raised it. The receive path, the transmit path and the modem lines report events to it. The block keeps one pending flag for each source. It masks those flags with an 8-bit enable register and picks the most urgent enabled one. It drives a single interrupt line and an identification byte that the bus side returns when the identification address is read.

Each pending flag is cleared by the register access that services its source. The bus decoder passes those accesses in as one-cycle strobes: identification read, line-status read, receive-buffer read, modem-status read and holding-register write. The holding-empty source is the exception. It is armed from a level input, not from a pulse. It is also released when software reads the identification byte while that source is the one shown. The upper bits of the identification byte report the FIFO configuration, which comes in from outside the block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00, no source is pending, `irq` is 0 and `ident` bits 3:0 read 0001.
- R2: A write to the enable register stores bits 5:0. Bits 7:6 always read back as 0.
- R3: `ident[7:6]` follows `fifo_state`, `ident[5]` follows `fifo_deep` and `ident[4]` is always 0.
- R4: `ident[0]` is 0 exactly when some enabled source is pending, and `irq` is its inverse. `ident[3:1]` holds the source code: 011 line status, 010 receive data, 110 receive timeout, 001 holding empty, 000 modem status. It is 000 when nothing is pending.
- R5: When several enabled sources are pending, only the most urgent is reported. The order is line status, then receive data, then receive timeout, then holding empty, then modem status.
- R6: Enable bit 2 gates line status. Bit 0 gates both receive data and timeout. Bit 1 gates holding empty and bit 3 gates modem status. A pending source whose bit is 0 is not reported and does not raise `irq`. It stays pending and is reported once its bit is set.
- R7: A line-status interrupt is cleared only by `rd_line`, and a modem-status interrupt only by `rd_modem`.
- R8: `rd_rxbuf` clears both the receive-data and the receive-timeout pending flags.
- R9: A 0-to-1 change of `tx_empty` makes the holding-empty source pending.
- R10: A write that changes enable bit 1 from 0 to 1 while `tx_empty` is 1 makes the holding-empty source pending.
- R11: The holding-empty source is cleared by `wr_txhold`. It is also cleared by `rd_ident` in a cycle where `ident[3:1]` shows 001 with `ident[0]` at 0. An `rd_ident` while another source is shown leaves it pending.
- R12: Enable bits 4 and 5 have no effect on `irq` or `ident`.
- R13: If an event and its clearing strobe arrive in the same cycle, the source ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_line | input | 1 | One-cycle pulse: receive line error seen |
| ev_rxav | input | 1 | One-cycle pulse: receive data available or trigger level reached |
| ev_tmo | input | 1 | One-cycle pulse: receive character timeout |
| tx_empty | input | 1 | Level: transmit holding register is empty |
| ev_modem | input | 1 | One-cycle pulse: a modem input changed |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| rd_ident | input | 1 | Identification byte read strobe |
| rd_line | input | 1 | Line status read strobe |
| rd_rxbuf | input | 1 | Receive buffer read strobe |
| rd_modem | input | 1 | Modem status read strobe |
| wr_txhold | input | 1 | Transmit holding register write strobe |
| fifo_state | input | 2 | FIFO state code copied into the identification byte |
| fifo_deep | input | 1 | Deep FIFO mode flag copied into the identification byte |
| en_q | output | 8 | Enable register contents |
| irq | output | 1 | Interrupt request, active high |
| ident | output | 8 | Identification byte |

## Verification
The identification byte and `irq` are built combinationally from the pending flags and the enable register. So a wrong pending flag shows at the ports in the first cycle after the event or strobe that caused it. That holds only while the flag's source is enabled and no more urgent source hides it. The tests therefore stack sources in known states and release them one strobe at a time, checking the byte after every step. A wrong clear rule then shows as a code that does not step down through the priority order, or as one that steps down too far. The holding-empty arming shows at the ports only through the cycle after an edge of `tx_empty` or after an enable write. Both paths are driven with the other sources idle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int NSRC  = 5;
  localparam int REG_W = 8;

  // Source slots, listed most urgent first
  localparam int S_LINE = 0;
  localparam int S_RXAV = 1;
  localparam int S_TMO  = 2;
  localparam int S_TXE  = 3;
  localparam int S_MDM  = 4;

  // Enable register bit positions
  localparam int EB_RX   = 0;
  localparam int EB_TX   = 1;
  localparam int EB_LINE = 2;
  localparam int EB_MDM  = 3;
  localparam logic [REG_W-1:0] EN_RSV_MASK = 8'hC0;

  localparam logic [2:0] C_LINE = 3'b011;
  localparam logic [2:0] C_RXAV = 3'b010;
  localparam logic [2:0] C_TMO  = 3'b110;
  localparam logic [2:0] C_TXE  = 3'b001;
  localparam logic [2:0] C_MDM  = 3'b000;

  // Expand the enable register into one mask bit per source slot
  function automatic logic [NSRC-1:0] src_mask(input logic [REG_W-1:0] en);
    logic [NSRC-1:0] m;
    m         = '0;
    m[S_LINE] = en[EB_LINE];
    m[S_RXAV] = en[EB_RX];
    m[S_TMO]  = en[EB_RX];
    m[S_TXE]  = en[EB_TX];
    m[S_MDM]  = en[EB_MDM];
    return m;
  endfunction

  // One-hot of the lowest set index (the most urgent request)
  function automatic logic [NSRC-1:0] first_set(input logic [NSRC-1:0] req);
    logic [NSRC-1:0] g;
    logic            taken;
    g     = '0;
    taken = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !taken) begin
        g[i]  = 1'b1;
        taken = 1'b1;
      end
    end
    return g;
  endfunction

  // Three-bit source code for a one-hot grant; 000 when empty
  function automatic logic [2:0] code_of(input logic [NSRC-1:0] g);
    logic [2:0] c;
    c = 3'b000;
    if (g[S_LINE]) c = C_LINE;
    if (g[S_RXAV]) c = C_RXAV;
    if (g[S_TMO])  c = C_TMO;
    if (g[S_TXE])  c = C_TXE;
    if (g[S_MDM])  c = C_MDM;
    return c;
  endfunction

endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
  import uirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q,
  output logic             tx_en_rise
);

  logic [REG_W-1:0] en_d;

  assign en_d       = wdata & ~EN_RSV_MASK;
  assign tx_en_rise = wr && wdata[EB_TX] && !en_q[EB_TX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= en_d;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & EN_RSV_MASK) == '0); // R2

endmodule

// File: rtl/uirq_txe_track.sv
module uirq_txe_track (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty,
  input  logic tx_en_rise,
  output logic arm
);

  // Starts high so an already-empty holder after reset is not seen as an edge
  logic empty_prev;
  logic empty_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_prev <= 1'b1;
    else        empty_prev <= tx_empty;
  end

  assign empty_rise = tx_empty && !empty_prev;
  assign arm        = empty_rise || (tx_en_rise && tx_empty);

endmodule

// File: rtl/uirq_pend_latch.sv
module uirq_pend_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (set[i]) pend[i] <= 1'b1;
      else if (clr[i]) pend[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> pend[i]); // R13

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !pend[i]); // R7
  end

endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] grant,
  output logic [2:0]      code,
  output logic            any
);

  assign grant = first_set(req);
  assign code  = code_of(grant);
  assign any   = |req;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_line,
  input  logic             ev_rxav,
  input  logic             ev_tmo,
  input  logic             tx_empty,
  input  logic             ev_modem,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_wdata,
  input  logic             rd_ident,
  input  logic             rd_line,
  input  logic             rd_rxbuf,
  input  logic             rd_modem,
  input  logic             wr_txhold,
  input  logic [1:0]       fifo_state,
  input  logic             fifo_deep,
  output logic [REG_W-1:0] en_q,
  output logic             irq,
  output logic [REG_W-1:0] ident
);

  logic            tx_en_rise;
  logic            txe_arm;
  logic [NSRC-1:0] src_set;
  logic [NSRC-1:0] src_clr;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] pend_en;
  logic [NSRC-1:0] grant;
  logic [2:0]      code;
  logic            any;
  logic            txe_shown_read;

  uirq_enable_reg u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (en_wr),
    .wdata      (en_wdata),
    .en_q       (en_q),
    .tx_en_rise (tx_en_rise)
  );

  uirq_txe_track u_txe (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_empty   (tx_empty),
    .tx_en_rise (tx_en_rise),
    .arm        (txe_arm)
  );

  assign txe_shown_read = rd_ident && grant[S_TXE];

  always_comb begin
    src_set         = '0;
    src_set[S_LINE] = ev_line;
    src_set[S_RXAV] = ev_rxav;
    src_set[S_TMO]  = ev_tmo;
    src_set[S_TXE]  = txe_arm;
    src_set[S_MDM]  = ev_modem;

    src_clr         = '0;
    src_clr[S_LINE] = rd_line;
    src_clr[S_RXAV] = rd_rxbuf;
    src_clr[S_TMO]  = rd_rxbuf;
    src_clr[S_TXE]  = wr_txhold || txe_shown_read;
    src_clr[S_MDM]  = rd_modem;
  end

  uirq_pend_latch #(.N(NSRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (src_set),
    .clr   (src_clr),
    .pend  (pend)
  );

  assign pend_en = pend & src_mask(en_q);

  uirq_prio_enc u_enc (
    .req   (pend_en),
    .grant (grant),
    .code  (code),
    .any   (any)
  );

  assign irq   = any;
  assign ident = {fifo_state, fifo_deep, 1'b0, code, ~any};

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[S_LINE] && en_q[EB_LINE]) |-> (ident[3:1] == C_LINE)); // R5

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & src_mask(en_q)) == '0) |-> (ident[0] && !irq)); // R6

  AST_TXE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    txe_arm |=> pend[S_TXE]); // R9

  AST_IDENT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ident && !ident[0] && ident[3:1] == C_TXE && !txe_arm) |=> !pend[S_TXE]); // R11

endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_line = 0, ev_rxav = 0, ev_tmo = 0, tx_empty = 0, ev_modem = 0;
  logic       en_wr = 0;
  logic [7:0] en_wdata = 0;
  logic       rd_ident = 0, rd_line = 0, rd_rxbuf = 0, rd_modem = 0, wr_txhold = 0;
  logic [1:0] fifo_state = 2'b11;
  logic       fifo_deep = 1'b0;
  logic [7:0] en_q;
  logic       irq;
  logic [7:0] ident;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_line(ev_line), .ev_rxav(ev_rxav), .ev_tmo(ev_tmo),
    .tx_empty(tx_empty), .ev_modem(ev_modem),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .rd_ident(rd_ident), .rd_line(rd_line), .rd_rxbuf(rd_rxbuf),
    .rd_modem(rd_modem), .wr_txhold(wr_txhold),
    .fifo_state(fifo_state), .fifo_deep(fifo_deep),
    .en_q(en_q), .irq(irq), .ident(ident)
  );

  // Expected identification byte, composed from the requirement text
  function automatic logic [7:0] exp_id(input logic [2:0] c, input logic pending);
    return {fifo_state, fifo_deep, 1'b0, c, !pending};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Drive at a falling edge, hold one cycle, release; caller samples afterwards
  task automatic wr_en(input logic [7:0] v);
    @(negedge clk); en_wr = 1; en_wdata = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_line   = 1;
      1: ev_rxav   = 1;
      2: ev_tmo    = 1;
      3: ev_modem  = 1;
      4: rd_ident  = 1;
      5: rd_line   = 1;
      6: rd_rxbuf  = 1;
      7: rd_modem  = 1;
      8: wr_txhold = 1;
      default: ;
    endcase
    @(negedge clk);
    {ev_line, ev_rxav, ev_tmo, ev_modem, rd_ident, rd_line, rd_rxbuf, rd_modem, wr_txhold} = '0;
  endtask

  task automatic t_reset;
    chk("R1 en_q", en_q, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 ident", ident, exp_id(3'b000, 0));
  endtask

  task automatic t_enable_reg;
    wr_en(8'hFF);
    chk("R2 reserved bits zero", en_q, 8'h3F);
    chk("R12 no pending, no irq", {7'd0, irq}, 8'h00);
    wr_en(8'h00);
    chk("R2 cleared", en_q, 8'h00);
  endtask

  task automatic t_codes;
    wr_en(8'h0F);
    pulse(3);
    chk("R4 modem code", ident, exp_id(3'b000, 1));
    chk("R4 irq", {7'd0, irq}, 8'h01);
    pulse(7);
    chk("R7 rd_modem clears", ident, exp_id(3'b000, 0));
    pulse(0);
    chk("R4 line code", ident, exp_id(3'b011, 1));
    pulse(6);
    chk("R7 rd_rxbuf leaves line", ident, exp_id(3'b011, 1));
    pulse(5);
    chk("R7 rd_line clears", ident, exp_id(3'b000, 0));
    pulse(1);
    chk("R4 rxav code", ident, exp_id(3'b010, 1));
    pulse(6);
    chk("R8 rd_rxbuf clears rxav", ident, exp_id(3'b000, 0));
    pulse(2);
    chk("R4 timeout code", ident, exp_id(3'b110, 1));
    pulse(6);
    chk("R8 rd_rxbuf clears timeout", ident, exp_id(3'b000, 0));
  endtask

  task automatic t_priority;
    @(negedge clk); tx_empty = 0;
    @(negedge clk);
    pulse(3);
    @(negedge clk); tx_empty = 1;
    @(negedge clk);
    chk("R9 empty edge arms", ident, exp_id(3'b001, 1));
    pulse(2);
    pulse(1);
    pulse(0);
    chk("R5 line first", ident, exp_id(3'b011, 1));
    pulse(4);
    chk("R11 ident read with line shown", ident, exp_id(3'b011, 1));
    pulse(5);
    chk("R5 rxav next", ident, exp_id(3'b010, 1));
    pulse(6);
    chk("R5 holding empty next", ident, exp_id(3'b001, 1));
    pulse(4);
    chk("R11 ident read releases", ident, exp_id(3'b000, 1));
    pulse(7);
    chk("R5 all cleared", ident, exp_id(3'b000, 0));
  endtask

  task automatic t_priority_tmo;
    pulse(2);
    pulse(3);
    chk("R5 timeout over modem", ident, exp_id(3'b110, 1));
    pulse(6);
    pulse(7);
    chk("R8 cleanup", ident, exp_id(3'b000, 0));
  endtask

  task automatic t_mask;
    wr_en(8'h00);
    pulse(0);
    chk("R6 masked line no irq", {7'd0, irq}, 8'h00);
    chk("R6 masked line ident", ident, exp_id(3'b000, 0));
    wr_en(8'h04);
    chk("R6 unmasked line shown", ident, exp_id(3'b011, 1));
    pulse(5);
    wr_en(8'h30);
    pulse(3);
    chk("R12 sleep bits no irq", {7'd0, irq}, 8'h00);
    chk("R12 sleep bits ident", ident, exp_id(3'b000, 0));
    wr_en(8'h38);
    chk("R6 modem shown", ident, exp_id(3'b000, 1));
    pulse(7);
    chk("R7 modem cleared", ident, exp_id(3'b000, 0));
  endtask

  task automatic t_tx_enable;
    wr_en(8'h00);
    wr_en(8'h02);
    chk("R10 enable rise while empty", ident, exp_id(3'b001, 1));
    pulse(8);
    chk("R11 holding write clears", ident, exp_id(3'b000, 0));
    wr_en(8'h02);
    chk("R10 rewrite of set bit no arm", ident, exp_id(3'b000, 0));
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1;
    @(negedge clk);
    chk("R9 second edge arms", ident, exp_id(3'b001, 1));
    pulse(8);
    chk("R11 cleared again", ident, exp_id(3'b000, 0));
  endtask

  task automatic t_collide;
    wr_en(8'h0F);
    @(negedge clk); ev_modem = 1; rd_modem = 1;
    @(negedge clk); ev_modem = 0; rd_modem = 0;
    chk("R13 event beats clear", ident, exp_id(3'b000, 1));
    pulse(7);
    chk("R13 then cleared", ident, exp_id(3'b000, 0));
  endtask

  task automatic t_fifo_bits;
    @(negedge clk); fifo_state = 2'b10; fifo_deep = 1'b1;
    #1;
    chk("R3 fifo fields", ident, 8'hA1);
    @(negedge clk); fifo_state = 2'b00; fifo_deep = 1'b0;
    #1;
    chk("R3 no fifo", ident, 8'h01);
    @(negedge clk); fifo_state = 2'b11;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable_reg();
    t_codes();
    t_priority();
    t_priority_tmo();
    t_mask();
    t_tx_enable();
    t_collide();
    t_fifo_bits();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule